// File: doc/BRIEF.md
# Low-Power Wait Wake Controller

This block manages the core's low-power wait state. When the instruction decoder signals that a WAIT instruction has executed, the controller drops the core clock enable on the next clock edge. This halts all core processing. The peripheral clock enable stays asserted, so timers and other peripherals keep running and can raise the interrupt that ends the wait. The block drives enable signals only. The clock-gating cell and the interrupt vector logic sit outside it.

Incoming interrupt requests carry a valid bit and a two-bit priority level. Each request passes through a two-flop synchronizer. It is then compared with the two-bit priority mask taken from the status register. Only a valid request whose level is strictly above the mask ends the wait. When it does, the block emits a one-cycle wake pulse and turns the core clock enable back on in the following cycle, so the core can start its interrupt service fetch. A synchronous reset also ends the wait at once.

Top module: `wait_wake_ctrl`

## Requirements
- R1: While and after reset, core_clk_en=1, periph_clk_en=1, wake_evt=0 and in_wait=0, and the controller is in the run state.
- R2: A wait_exec=1 sampled at a clock edge while running makes in_wait=1 and core_clk_en=0 from that edge on.
- R3: periph_clk_en is 1 in every cycle, in every state.
- R4: Only a request with irq_vld=1 and irq_lvl strictly greater than sr_mask ends the wait. Levels and mask compare as unsigned numbers 0..3. With sr_mask=3, no request can wake the controller.
- R5: A qualifying request is first sampled at edge E. It passes through two synchronizer flops, and wake_evt goes high after edge E+2.
- R6: wake_evt is a single-cycle pulse. In that cycle, in_wait=0 and core_clk_en is still 0. core_clk_en returns to 1 in the next cycle.
- R7: While waiting, a request that is masked or not valid is ignored. in_wait stays 1 and no wake_evt is produced.
- R8: Asserting rst during the wait returns the controller to run at the next edge, with core_clk_en=1 and in_wait=0.
- R9: wait_exec is ignored while the controller is already waiting or waking.
- R10: A qualifying request that is already synchronized when the wait is entered produces wake_evt right after the edge that follows entry.
- R11: A request arriving while running produces no wake_evt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_exec | input | 1 | WAIT instruction executed this cycle |
| irq_vld | input | 1 | Interrupt request present (asynchronous) |
| irq_lvl | input | 2 | Interrupt request priority level |
| sr_mask | input | 2 | Current priority mask from status register |
| core_clk_en | output | 1 | Clock enable for core logic |
| periph_clk_en | output | 1 | Clock enable for peripherals |
| wake_evt | output | 1 | One-cycle wake pulse |
| in_wait | output | 1 | Controller is in the wait state |

## Verification
On every cycle, the assertions check entry into the wait state, that the wait is held when no qualifying request is present, that a wake pulse is always caused by a qualifying request seen during the wait, and the pulse shape together with the re-enable of the core clock. Only the bench scenarios can show the exact synchronizer latency and the mask comparison at its boundaries (equal level, invalid request, mask of 3). The same goes for a request already pending when the wait starts, and for reset ending the wait.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

    localparam int LVL_W = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_WAKE = 2'd2
    } wwc_state_e;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
    } irq_req_t;

    function automatic logic beats_mask(irq_req_t r, logic [LVL_W-1:0] m);
        return r.vld && (r.lvl > m);
    endfunction

endpackage

// File: rtl/wwc_irq_sync.sv
module wwc_irq_sync
    import wwc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  irq_req_t d,
    output irq_req_t q
);

    irq_req_t stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wwc_wake_cmp.sv
module wwc_wake_cmp
    import wwc_pkg::*;
(
    input  irq_req_t         req,
    input  logic [LVL_W-1:0] mask,
    output logic             wake_req
);

    always_comb begin
        wake_req = beats_mask(req, mask);
    end

endmodule

// File: rtl/wwc_wait_fsm.sv
module wwc_wait_fsm
    import wwc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wait_exec,
    input  logic wake_req,
    output logic core_clk_en,
    output logic periph_clk_en,
    output logic wake_evt,
    output logic in_wait
);

    wwc_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (wait_exec) state_nx = ST_WAIT;
            ST_WAIT: if (wake_req)  state_nx = ST_WAKE;
            ST_WAKE: state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    assign core_clk_en   = (state == ST_RUN);
    assign periph_clk_en = 1'b1;
    assign wake_evt      = (state == ST_WAKE);
    assign in_wait       = (state == ST_WAIT);

    // R2: a WAIT seen while running enters the wait state
    assert_enter_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && wait_exec) |=> (in_wait && !core_clk_en));

    // R7: without a qualifying request the wait holds
    assert_hold_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (in_wait && !wake_req) |=> in_wait);

    // R4: a wake pulse always follows a qualifying request seen while waiting
    assert_wake_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_evt) |-> $past(in_wait && wake_req));

    // R6: single-cycle pulse, then the core clock comes back
    assert_wake_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> (!wake_evt && core_clk_en));

    // R6: core clock stays off during the wake pulse
    assert_wake_gated_R6: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> (!core_clk_en && !in_wait));

endmodule

// File: rtl/wait_wake_ctrl.sv
module wait_wake_ctrl
    import wwc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wait_exec,
    input  logic             irq_vld,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0] sr_mask,
    output logic             core_clk_en,
    output logic             periph_clk_en,
    output logic             wake_evt,
    output logic             in_wait
);

    irq_req_t req_raw, req_sync;
    logic     wake_req;

    assign req_raw.vld = irq_vld;
    assign req_raw.lvl = irq_lvl;

    wwc_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_raw),
        .q   (req_sync)
    );

    wwc_wake_cmp u_cmp (
        .req      (req_sync),
        .mask     (sr_mask),
        .wake_req (wake_req)
    );

    wwc_wait_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .wait_exec     (wait_exec),
        .wake_req      (wake_req),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .wake_evt      (wake_evt),
        .in_wait       (in_wait)
    );

endmodule

// File: tb/wait_wake_ctrl_tb.sv
`timescale 1ns/1ps
module wait_wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wait_exec = 1'b0;
    logic       irq_vld = 1'b0;
    logic [1:0] irq_lvl = 2'd0;
    logic [1:0] sr_mask = 2'd0;
    logic       core_clk_en, periph_clk_en, wake_evt, in_wait;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wait_wake_ctrl u_dut (
        .clk(clk), .rst(rst), .wait_exec(wait_exec),
        .irq_vld(irq_vld), .irq_lvl(irq_lvl), .sr_mask(sr_mask),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .wake_evt(wake_evt), .in_wait(in_wait)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver helper: qualifying request applied now, wake expected after 3 edges
    task automatic push_wake(int delay);
        exp_q.push_back(cyc + delay);
    endtask

    task automatic enter_wait();
        wait_exec = 1'b1;
        tick(1);
        wait_exec = 1'b0;
    endtask

    // monitor: every wake pulse must match the next expected cycle (R5, R10, R11)
    always @(negedge clk) begin
        if (!rst && wake_evt) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 actual=unexpected wake expected=none at cycle %0d", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    errors++;
                    $display("FAIL R5 actual=wake at %0d expected=wake at %0d", cyc, e);
                end
            end
        end
        if (periph_clk_en !== 1'b1) begin
            checks++;
            errors++;
            $display("FAIL R3 actual=%0b expected=1", periph_clk_en);
        end
    end

    initial begin
        tick(3);
        // R1: reset values
        chk("R1 core_clk_en", core_clk_en, 1'b1);
        chk("R1 periph_clk_en", periph_clk_en, 1'b1);
        chk("R1 wake_evt", wake_evt, 1'b0);
        chk("R1 in_wait", in_wait, 1'b0);
        rst = 1'b0;
        tick(2);

        // R11: request while running does nothing
        irq_vld = 1'b1; irq_lvl = 2'd3;
        tick(4);
        chk("R11 in_wait", in_wait, 1'b0);
        irq_vld = 1'b0;
        tick(4);

        // R2, R5, R6: mask 0, level 1 wakes
        sr_mask = 2'd0;
        enter_wait();
        chk("R2 in_wait", in_wait, 1'b1);
        chk("R2 core_clk_en", core_clk_en, 1'b0);
        chk("R3 periph_clk_en", periph_clk_en, 1'b1);
        tick(2);
        irq_vld = 1'b1; irq_lvl = 2'd1;
        push_wake(3);
        tick(1);
        irq_vld = 1'b0;
        tick(1);
        chk("R5 no early wake", wake_evt, 1'b0);
        tick(1);
        chk("R6 wake_evt", wake_evt, 1'b1);
        chk("R6 in_wait low", in_wait, 1'b0);
        chk("R6 core still off", core_clk_en, 1'b0);
        tick(1);
        chk("R6 pulse ends", wake_evt, 1'b0);
        chk("R6 core back on", core_clk_en, 1'b1);
        tick(4);

        // R7, R4, R9: mask 2, equal level and invalid request ignored
        sr_mask = 2'd2;
        enter_wait();
        irq_vld = 1'b1; irq_lvl = 2'd2;
        tick(6);
        chk("R7 equal level ignored", in_wait, 1'b1);
        irq_vld = 1'b0; irq_lvl = 2'd3;
        tick(4);
        chk("R4 invalid ignored", in_wait, 1'b1);
        enter_wait();
        tick(2);
        chk("R9 wait_exec ignored", in_wait, 1'b1);
        irq_vld = 1'b1;
        push_wake(3);
        tick(1);
        irq_vld = 1'b0;
        tick(2);
        chk("R4 level above mask wakes", wake_evt, 1'b1);
        tick(5);

        // R4, R8: mask 3 blocks all, reset exits
        sr_mask = 2'd3;
        enter_wait();
        irq_vld = 1'b1; irq_lvl = 2'd3;
        tick(6);
        chk("R4 mask 3 blocks", in_wait, 1'b1);
        rst = 1'b1;
        tick(1);
        chk("R8 in_wait", in_wait, 1'b0);
        chk("R8 core_clk_en", core_clk_en, 1'b1);
        rst = 1'b0;
        irq_vld = 1'b0;
        tick(4);

        // R10: request already synchronized when wait begins
        sr_mask = 2'd0;
        irq_vld = 1'b1; irq_lvl = 2'd1;
        tick(3);
        wait_exec = 1'b1;
        push_wake(2);
        tick(1);
        wait_exec = 1'b0;
        chk("R10 entered wait", in_wait, 1'b1);
        tick(1);
        chk("R10 immediate wake", wake_evt, 1'b1);
        irq_vld = 1'b0;
        tick(6);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 actual=%0d missing wakes expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule